// File: doc/BRIEF.md
# GPU Source Operand Resolver

This block resolves one 9-bit source operand code into an operand value for a single lane. The code space is shared by several kinds of source: scalar registers, a null source, the condition bit, a set of built-in integer and floating-point constants, the instruction's trailing literal, and the current lane's vector registers. Register storage lives outside the block. The block reaches it through a read request port that uses a valid/ready handshake, and the read data returns in the same cycle as ready.

The caller gives an operand width of 16, 32 or 64 bits. The width selects which constant encoding is used and how register data is formatted. In 64-bit mode a register source is read as a pair: the low word first, then the high word. In 16-bit mode with the short vector encoding, bit 7 of the vector index selects the upper or lower half of the register. The result is presented through a registered output that is valid for one cycle.

Top module: `srcres_top`

## Requirements
- R1: Codes 0..127, except 124, issue a scalar register read with vector flag 0 and index equal to the code. In 32-bit mode the result is the returned word, zero-extended to 64 bits.
- R2: Code 124 returns zero and code 253 returns the condition input zero-extended. Neither issues a register read.
- R3: Codes 128..192 return the integers 0..64. Codes 193..208 return -1..-16 in two's complement at the active width.
- R4: Codes 240..247 return +0.5, -0.5, +1, -1, +2, -2, +4, -4 in order, in the float format of the active width. Code 248 returns 1/(2π): 16'h3118 in 16-bit mode, 32'h3E22F983 in 32-bit mode, 64'h3FC45F306DC9C883 in 64-bit mode.
- R5: Codes 209..239, 249..252 and 254 return zero.
- R6: Code 255 returns the literal input. It returns bits 63:0 in 64-bit mode, bits 31:0 in 32-bit mode and bits 15:0 in 16-bit mode.
- R7: Codes 256..511 issue a vector register read with vector flag 1, index equal to code minus 256, and the lane that was captured with the request.
- R8: In 16-bit mode (width 1) every result is zero-extended from 16 bits. With the short flag set, a vector code reads register index bits 6:0, and bit 7 set selects bits 31:16 (clear selects bits 15:0). Without the flag, the low half of the register is used.
- R9: In 64-bit mode (width 2) a register source reads index n and then index n+1, giving {word(n+1), word(n)}. Scalar codes 106..127 and vector code 511 make a single read, and their high word is zero.
- R10: A register read request keeps its valid, index and vector flag stable until it is accepted. No new operand is accepted while a read is outstanding.
- R11: Width codes are 0 for 32-bit, 1 for 16-bit, 2 for 64-bit, and 3 behaves as 32-bit. A result that needs no register read is valid on the cycle after the operand is accepted. A register result is valid on the cycle after its last read handshake. After reset the output is not valid and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand request valid |
| in_ready_o | output | 1 | Block can accept an operand |
| code_i | input | 9 | Source operand code |
| width_i | input | 2 | Operand width: 0=32, 1=16, 2=64, 3=32 |
| short_i | input | 1 | 16-bit short vector encoding (half select in index bit 7) |
| lane_i | input | LANE_W | Lane whose vector registers are read |
| scc_i | input | 1 | Condition bit |
| literal_i | input | 64 | Trailing literal, pre-positioned for 64-bit use |
| rf_req_valid_o | output | 1 | Register read request valid |
| rf_req_ready_i | input | 1 | Register read accepted; data valid this cycle |
| rf_req_vec_o | output | 1 | 1 = vector register, 0 = scalar register |
| rf_req_idx_o | output | 8 | Register index |
| rf_req_lane_o | output | LANE_W | Lane for a vector read |
| rf_rdata_i | input | 32 | Read data, valid with rf_req_ready_i |
| out_valid_o | output | 1 | Result valid, one-cycle pulse |
| out_data_o | output | 64 | Resolved operand value |

## Verification
The embedded assertions check four things on every cycle: a stalled read request holds steady, a pair read advances the index by exactly one, scalar requests never index beyond the scalar file, and 16-bit results carry no upper bits. They also check that non-register sources respond on the next cycle. The decoded value of each code is shown only by the bench's scenarios, which compare results against an independent model of the code map. The same applies to the half selection, the pair edge cases at the scalar and vector limits, and the number of reads each code produces. Those scenarios run across all widths, with a register port that stalls periodically and sometimes for several cycles in a row.

// File: rtl/srcres_pkg.sv
package srcres_pkg;
  typedef enum logic [1:0] {WD_32 = 2'd0, WD_16 = 2'd1, WD_64 = 2'd2, WD_32B = 2'd3} width_e;
  typedef enum logic [2:0] {K_SREG, K_VREG, K_CONST, K_LIT, K_SCC, K_ZERO} kind_e;

  localparam int CODE_W     = 9;
  localparam int IDX_W      = 8;
  localparam int NULL_CODE  = 124;
  localparam int SCC_CODE   = 253;
  localparam int LIT_CODE   = 255;
  localparam int PAIR_LIMIT = 106;
  localparam int IPOS_LO    = 128;
  localparam int IPOS_HI    = 192;
  localparam int INEG_HI    = 208;
  localparam int FLT_LO     = 240;
  localparam int FLT_HI     = 247;
  localparam int INV2PI     = 248;

  typedef struct packed {
    kind_e            kind;
    logic [IDX_W-1:0] idx;
    logic             half;
    logic             pair;
  } dec_t;
endpackage

// File: rtl/srcres_decode.sv
module srcres_decode
  import srcres_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  width_e            width_i,
  input  logic              short_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o = '{kind: K_CONST, idx: '0, half: 1'b0, pair: 1'b0};
    if (code_i[CODE_W-1]) begin
      dec_o.kind = K_VREG;
      if (width_i == WD_16 && short_i) begin
        dec_o.idx  = {1'b0, code_i[6:0]};
        dec_o.half = code_i[7];
      end else begin
        dec_o.idx = code_i[IDX_W-1:0];
      end
      dec_o.pair = (width_i == WD_64) && (code_i[IDX_W-1:0] != '1);
    end else if (code_i < CODE_W'(IPOS_LO)) begin
      if (code_i == CODE_W'(NULL_CODE)) begin
        dec_o.kind = K_ZERO;
      end else begin
        dec_o.kind = K_SREG;
        dec_o.idx  = {1'b0, code_i[6:0]};
        dec_o.pair = (width_i == WD_64) && (code_i < CODE_W'(PAIR_LIMIT));
      end
    end else if (code_i == CODE_W'(SCC_CODE)) begin
      dec_o.kind = K_SCC;
    end else if (code_i == CODE_W'(LIT_CODE)) begin
      dec_o.kind = K_LIT;
    end
  end
endmodule

// File: rtl/srcres_const.sv
module srcres_const
  import srcres_pkg::*;
(
  input  logic [7:0] code_i,
  input  width_e     width_i,
  output logic [63:0] val_o
);
  logic [63:0] raw;
  logic [1:0]  mag;

  assign mag = code_i[2:1];

  always_comb begin
    raw = '0;
    if (code_i >= 8'(IPOS_LO) && code_i <= 8'(IPOS_HI)) begin
      raw = 64'(code_i - 8'(IPOS_LO));
    end else if (code_i > 8'(IPOS_HI) && code_i <= 8'(INEG_HI)) begin
      raw = 64'd0 - 64'(code_i - 8'(IPOS_HI));
    end else if (code_i >= 8'(FLT_LO) && code_i <= 8'(FLT_HI)) begin
      // exponent steps by one per magnitude, odd code is negative
      unique case (width_i)
        WD_16:   raw = 64'({code_i[0], 15'(15'h3800 + (15'(mag) << 10))});
        WD_64:   raw = {code_i[0], 63'(63'h3FE0_0000_0000_0000 + (63'(mag) << 52))};
        default: raw = 64'({code_i[0], 31'(31'h3F00_0000 + (31'(mag) << 23))});
      endcase
    end else if (code_i == 8'(INV2PI)) begin
      unique case (width_i)
        WD_16:   raw = 64'h3118;
        WD_64:   raw = 64'h3FC4_5F30_6DC9_C883;
        default: raw = 64'h3E22_F983;
      endcase
    end
  end

  always_comb begin
    unique case (width_i)
      WD_16:   val_o = {48'd0, raw[15:0]};
      WD_64:   val_o = raw;
      default: val_o = {32'd0, raw[31:0]};
    endcase
  end
endmodule

// File: rtl/srcres_top.sv
module srcres_top
  import srcres_pkg::*;
#(
  parameter int LANE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [8:0]        code_i,
  input  logic [1:0]        width_i,
  input  logic              short_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              scc_i,
  input  logic [63:0]       literal_i,
  output logic              rf_req_valid_o,
  input  logic              rf_req_ready_i,
  output logic              rf_req_vec_o,
  output logic [7:0]        rf_req_idx_o,
  output logic [LANE_W-1:0] rf_req_lane_o,
  input  logic [31:0]       rf_rdata_i,
  output logic              out_valid_o,
  output logic [63:0]       out_data_o
);
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} state_e;

  state_e            state_q;
  dec_t              dec_in, dec_q;
  width_e            width_in, width_q;
  logic [LANE_W-1:0] lane_q;
  logic [31:0]       lo_q;
  logic [63:0]       const_val, imm_val, rd_val;
  logic              accept, rf_hs, in_is_reg;

  assign width_in = width_e'(width_i);

  srcres_decode u_decode (
    .code_i (code_i),
    .width_i(width_in),
    .short_i(short_i),
    .dec_o  (dec_in)
  );

  srcres_const u_const (
    .code_i (code_i[7:0]),
    .width_i(width_in),
    .val_o  (const_val)
  );

  assign in_ready_o = (state_q == S_IDLE);
  assign accept     = in_valid_i && in_ready_o;
  assign in_is_reg  = (dec_in.kind == K_SREG) || (dec_in.kind == K_VREG);

  always_comb begin
    unique case (dec_in.kind)
      K_LIT: begin
        unique case (width_in)
          WD_16:   imm_val = {48'd0, literal_i[15:0]};
          WD_64:   imm_val = literal_i;
          default: imm_val = {32'd0, literal_i[31:0]};
        endcase
      end
      K_SCC:   imm_val = {63'd0, scc_i};
      K_CONST: imm_val = const_val;
      default: imm_val = '0;
    endcase
  end

  assign rf_req_valid_o = (state_q != S_IDLE);
  assign rf_req_vec_o   = (dec_q.kind == K_VREG);
  assign rf_req_idx_o   = (state_q == S_HI) ? dec_q.idx + 8'd1 : dec_q.idx;
  assign rf_req_lane_o  = lane_q;
  assign rf_hs          = rf_req_valid_o && rf_req_ready_i;

  // single-word read result, formatted for the captured width
  always_comb begin
    unique case (width_q)
      WD_16:   rd_val = {48'd0, dec_q.half ? rf_rdata_i[31:16] : rf_rdata_i[15:0]};
      default: rd_val = {32'd0, rf_rdata_i};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      dec_q       <= '{kind: K_ZERO, idx: '0, half: 1'b0, pair: 1'b0};
      width_q     <= WD_32;
      lane_q      <= '0;
      lo_q        <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          dec_q   <= dec_in;
          width_q <= width_in;
          lane_q  <= lane_i;
          if (in_is_reg) begin
            state_q <= S_LO;
          end else begin
            out_valid_o <= 1'b1;
            out_data_o  <= imm_val;
          end
        end
        S_LO: if (rf_hs) begin
          lo_q <= rf_rdata_i;
          if (dec_q.pair) begin
            state_q <= S_HI;
          end else begin
            state_q     <= S_IDLE;
            out_valid_o <= 1'b1;
            out_data_o  <= rd_val;
          end
        end
        S_HI: if (rf_hs) begin
          state_q     <= S_IDLE;
          out_valid_o <= 1'b1;
          out_data_o  <= {rf_rdata_i, lo_q};
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_req_valid_o && !rf_req_ready_i |=> rf_req_valid_o && $stable(rf_req_idx_o) && $stable(rf_req_vec_o));

  // R9
  pair_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_hs && state_q == S_LO && dec_q.pair |=> rf_req_valid_o && rf_req_idx_o == $past(rf_req_idx_o) + 8'd1);

  // R1
  sreg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_req_valid_o && !rf_req_vec_o |-> !rf_req_idx_o[7]);

  // R8
  half_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && width_q == WD_16 |-> out_data_o[63:16] == 48'd0);

  // R11
  imm_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !in_is_reg |=> out_valid_o && !rf_req_valid_o);
endmodule

// File: tb/srcres_top_bench.sv
module srcres_top_bench;
  localparam int LANE_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              in_valid = 1'b0, in_ready;
  logic [8:0]        code = '0;
  logic [1:0]        width = '0;
  logic              short_f = 1'b0;
  logic [LANE_W-1:0] lane = '0;
  logic              scc = 1'b0;
  logic [63:0]       lit = '0;
  logic              rf_valid, rf_ready, rf_vec;
  logic [7:0]        rf_idx;
  logic [LANE_W-1:0] rf_lane;
  logic [31:0]       rf_rdata;
  logic              out_valid;
  logic [63:0]       out_data;

  int n_run = 0, n_fail = 0, nreq = 0;
  logic [7:0] rdy_cnt = 8'd0;
  logic       rdy_q = 1'b0;
  logic       force_stall = 1'b0;
  logic       prev_stall = 1'b0;
  logic [7:0] prev_idx = 8'd0;
  logic [LANE_W-1:0] cur_lane = '0;

  function automatic logic [31:0] sfun(logic [7:0] i);
    return {8'h5A, i, 8'hC3, ~i};
  endfunction

  function automatic logic [31:0] vfun(logic [LANE_W-1:0] l, logic [7:0] i);
    return {i, 3'b101, l, ~i, 8'h77 ^ {3'b000, l}};
  endfunction

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 8'd1;
    rdy_q   <= !force_stall && (rdy_cnt[1:0] != 2'd3);
  end
  assign rf_ready = rdy_q;
  assign rf_rdata = rf_vec ? vfun(rf_lane, rf_idx) : sfun(rf_idx);

  srcres_top #(.LANE_W(LANE_W)) u_srcres_top (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .code_i(code), .width_i(width), .short_i(short_f), .lane_i(lane),
    .scc_i(scc), .literal_i(lit),
    .rf_req_valid_o(rf_valid), .rf_req_ready_i(rf_ready), .rf_req_vec_o(rf_vec),
    .rf_req_idx_o(rf_idx), .rf_req_lane_o(rf_lane), .rf_rdata_i(rf_rdata),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // port-level monitor of the read channel
  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_valid) begin
        chk(!in_ready, "R10 busy", 64'(in_ready), 64'd0);
        chk(rf_lane == cur_lane, "R7 lane", 64'(rf_lane), 64'(cur_lane));
        if (prev_stall) chk(rf_idx == prev_idx, "R10 hold", 64'(rf_idx), 64'(prev_idx));
        if (rf_ready) nreq++;
        prev_stall = !rf_ready;
        prev_idx   = rf_idx;
      end else begin
        if (prev_stall) chk(1'b0, "R10 dropped", 64'd0, 64'd1);
        prev_stall = 1'b0;
      end
    end
  end

  function automatic logic [63:0] exp_val(int c, int w, bit sh, logic [LANE_W-1:0] l, bit s, logic [63:0] lt);
    logic [63:0] v;
    logic [31:0] r, hi;
    logic [15:0] h;
    logic [31:0] f;
    logic [63:0] d;
    int vi;
    v = '0;
    if (c >= 256) begin
      vi = c - 256;
      if (w == 1 && sh) begin
        r = vfun(l, 8'(vi % 128));
        return (vi >= 128) ? 64'(r[31:16]) : 64'(r[15:0]);
      end
      r = vfun(l, 8'(vi));
      if (w == 1) return 64'(r[15:0]);
      if (w == 2) begin
        hi = (vi != 255) ? vfun(l, 8'(vi + 1)) : 32'd0;
        return {hi, r};
      end
      return 64'(r);
    end
    if (c < 128) begin
      if (c == 124) return 64'd0;
      r = sfun(8'(c));
      if (w == 1) return 64'(r[15:0]);
      if (w == 2) begin
        hi = (c < 106) ? sfun(8'(c + 1)) : 32'd0;
        return {hi, r};
      end
      return 64'(r);
    end
    if (c == 253) return 64'(s);
    if (c == 255) begin
      if (w == 1) return 64'(lt[15:0]);
      if (w == 2) return lt;
      return 64'(lt[31:0]);
    end
    if (c <= 192) v = 64'(c - 128);
    else if (c <= 208) v = -64'(c - 192);
    else begin
      h = 16'h0; f = 32'h0; d = 64'h0;
      case (c)
        240: begin h = 16'h3800; f = 32'h3F00_0000; d = 64'h3FE0_0000_0000_0000; end
        241: begin h = 16'hB800; f = 32'hBF00_0000; d = 64'hBFE0_0000_0000_0000; end
        242: begin h = 16'h3C00; f = 32'h3F80_0000; d = 64'h3FF0_0000_0000_0000; end
        243: begin h = 16'hBC00; f = 32'hBF80_0000; d = 64'hBFF0_0000_0000_0000; end
        244: begin h = 16'h4000; f = 32'h4000_0000; d = 64'h4000_0000_0000_0000; end
        245: begin h = 16'hC000; f = 32'hC000_0000; d = 64'hC000_0000_0000_0000; end
        246: begin h = 16'h4400; f = 32'h4080_0000; d = 64'h4010_0000_0000_0000; end
        247: begin h = 16'hC400; f = 32'hC080_0000; d = 64'hC010_0000_0000_0000; end
        248: begin h = 16'h3118; f = 32'h3E22_F983; d = 64'h3FC4_5F30_6DC9_C883; end
        default: ;
      endcase
      if (w == 1) return 64'(h);
      if (w == 2) return d;
      return 64'(f);
    end
    if (w == 1) return 64'(v[15:0]);
    if (w == 2) return v;
    return 64'(v[31:0]);
  endfunction

  function automatic int exp_reads(int c, int w);
    if (c >= 256) return (w == 2 && c != 511) ? 2 : 1;
    if (c < 128 && c != 124) return (w == 2 && c < 106) ? 2 : 1;
    return 0;
  endfunction

  function automatic string tag_of(int c, int w, bit sh);
    if (c >= 256) return (w == 1) ? (sh ? "R8 short" : "R8 low") : (w == 2) ? "R9 vpair" : "R7 vreg";
    if (c == 124 || c == 253) return "R2 null/scc";
    if (c < 128) return (w == 2) ? "R9 spair" : "R1 sreg";
    if (c == 255) return "R6 literal";
    if (c <= 208) return "R3 int";
    if (c >= 240 && c <= 248) return "R4 float";
    return "R5 undefined";
  endfunction

  task automatic run(input int c, input int w, input bit sh, input logic [LANE_W-1:0] l,
                     input bit s, input logic [63:0] lt);
    logic [63:0] e;
    int n0, lat, er;
    e  = exp_val(c, w, sh, l, s, lt);
    er = exp_reads(c, w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; code = 9'(c); width = 2'(w); short_f = sh; lane = l; scc = s; lit = lt;
    cur_lane = l;
    n0 = nreq;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk(out_valid, {tag_of(c, w, sh), " valid"}, 64'(out_valid), 64'd1);
    chk(out_data == e, tag_of(c, w, sh), out_data, e);
    chk((nreq - n0) == er, {tag_of(c, w, sh), " reads"}, 64'(nreq - n0), 64'(er));
    if (er == 0) chk(lat == 1, "R11 latency", 64'(lat), 64'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin : main
    int codes[36];
    int it;
    codes = '{0, 5, 63, 105, 106, 124, 127, 128, 150, 192, 193, 200, 208, 209, 239,
              240, 241, 242, 243, 244, 245, 246, 247, 248, 249, 253, 254, 255,
              256, 300, 383, 384, 400, 510, 511, 270};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!out_valid, "R11 reset valid", 64'(out_valid), 64'd0);
    chk(in_ready, "R11 reset ready", 64'(in_ready), 64'd1);
    chk(!rf_valid, "R11 reset req", 64'(rf_valid), 64'd0);
    rst_n = 1'b1;
    it = 0;
    for (int w = 0; w < 4; w++) begin
      for (int sh = 0; sh < 2; sh++) begin
        foreach (codes[k]) begin
          run(codes[k], w, sh[0], LANE_W'(it * 7), it[0],
              {32'hDEAD_BEEF ^ 32'(it), 32'h1234_5678 + 32'(it)});
          it++;
        end
      end
    end
    // R10 long stall on a vector pair and on a scalar read
    force_stall = 1'b1;
    fork
      run(290, 2, 1'b0, 5'd9, 1'b0, 64'd0);
      begin repeat (6) @(negedge clk); force_stall = 1'b0; end
    join
    force_stall = 1'b1;
    fork
      run(17, 0, 1'b0, 5'd3, 1'b1, 64'd0);
      begin repeat (5) @(negedge clk); force_stall = 1'b0; end
    join
    // R2 condition bit both values in 64-bit mode
    run(253, 2, 1'b0, 5'd0, 1'b1, 64'd0);
    run(253, 2, 1'b0, 5'd0, 1'b0, 64'd0);
    // R6 literal with high word set
    run(255, 2, 1'b0, 5'd0, 1'b0, 64'hFEDC_BA98_7654_3210);
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule